// File: doc/BRIEF.md
# Two-Level Interrupt Acknowledge Sequencer

This block joins two eight-line priority resolvers into one sixteen-line interrupt source for a processor. Request inputs 0 to 7 feed the primary resolver and inputs 8 to 15 feed the secondary resolver. The secondary resolver reports into line 2 of the primary. The block drives a single interrupt line to the processor. When the processor asks for an acknowledge, the block returns an 8-bit vector. The upper five bits of that vector come from a per-resolver base value. The lower three bits name the winning line of the resolver that owns the interrupt.

An acknowledge always starts at the primary resolver. If the primary's winner is line 2, the sequencer goes on to the secondary resolver and takes that resolver's winner. Otherwise the secondary is left alone. When no request is found at a level, the vector falls back to line 7 of that level and is marked as spurious. Each line is either edge-latched or level-following. Edge-latched lines keep their request until it is acknowledged. Level-following lines report their input level directly. Base values and line kinds are parameters.

Top module: `pic_cascade_top`

## Requirements
- R1: Request input r belongs to resolver r>>3 on local line r&7. A vector is formed as {BASE[7:3], line}. With the default bases, input 0 gives 8'h40 and input 8 gives 8'h70.
- R2: A rising edge on an edge-latched primary line raises `irq_out` after the next clock edge. The line stays pending after its input falls, until it is acknowledged.
- R3: A winning request in the secondary resolver sets primary line 2 while the sequencer is idle, so `irq_out` rises. External input 2 has no effect.
- R4: In each resolver the lowest-numbered pending line wins. At the primary level, the secondary's requests rank as line 2: line 1 beats them and line 3 loses to them.
- R5: `vec_valid` is a one-cycle pulse driven by the register that is loaded two clock edges after the edge that samples `ack_req`. An `ack_req` that arrives while a sequence is running is ignored.
- R6: When the primary winner is not line 2, the acknowledge clears only that primary line. The vector is the primary base plus the line, and the secondary is never acknowledged in the same cycle as the primary.
- R7: When the primary winner is line 2, the acknowledge clears primary line 2 and the secondary winner, and the vector is the secondary base plus that line. Requests still pending in the secondary raise `irq_out` again. A primary-base vector never carries line 2.
- R8: An acknowledge with nothing pending at the primary returns the primary base plus 7 and changes no request state.
- R9: A cascade acknowledge that finds the secondary empty returns the secondary base plus 7.
- R10: Level-following lines are pending exactly while their input is high, and an acknowledge does not clear them. Defaults: primary line 5 (input 5) and secondary line 6 (input 14).
- R11: While reset is high and after it is released, `irq_out` and `vec_valid` are 0 and `vec_out` is 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 16 | Interrupt request inputs; 0–7 primary, 8–15 secondary |
| ack_req | input | 1 | Acknowledge request from the processor, sampled on the clock edge |
| irq_out | output | 1 | Interrupt to the processor; high while the primary has a winner |
| vec_out | output | 8 | Vector of the last acknowledge, held between sequences |
| vec_valid | output | 1 | One-cycle strobe marking a new `vec_out` |

## Verification
The hardest case to reach is the secondary spurious vector. It needs primary line 2 latched while the secondary has nothing to offer, and edge-latched secondary lines never lose a request without an acknowledge. The stimulus holds the level-following input 14 high so that the cascade request is latched at the primary. It then lowers input 14 before the next acknowledge, which makes the cascade step find the secondary empty. A held `ack_req` spanning a whole sequence shows that requests arriving while a sequence is running are dropped, because a second pending line is left untouched.

// File: rtl/pic_cascade_pkg.sv
package pic_cascade_pkg;

    localparam int LINES      = 8;
    localparam int LW         = $clog2(LINES);
    localparam int CTRLS      = 2;
    localparam int TOTAL      = LINES * CTRLS;
    localparam int VEC_W      = 8;

    localparam logic [LW-1:0] CASCADE_LINE  = LW'(2);
    localparam logic [LW-1:0] SPURIOUS_LINE = LW'(LINES - 1);

    typedef logic [LINES-1:0] line_vec_t;

    typedef struct packed {
        logic          valid;
        logic [LW-1:0] line;
    } winner_t;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_PRIMARY,
        SEQ_EMIT
    } seq_state_t;

    // Lowest-numbered pending line wins.
    function automatic winner_t pick_winner(input line_vec_t pend);
        winner_t w;
        w = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (pend[i]) begin
                w.valid = 1'b1;
                w.line  = LW'(i);
            end
        end
        return w;
    endfunction

    function automatic logic [VEC_W-1:0] form_vector(input logic [VEC_W-1:0] base,
                                                    input logic [LW-1:0]    line);
        return {base[VEC_W-1:LW], line};
    endfunction

endpackage

// File: rtl/pic_line_resolver.sv
module pic_line_resolver
    import pic_cascade_pkg::*;
#(
    parameter line_vec_t LEVEL_MASK  = '0,
    parameter line_vec_t IGNORE_MASK = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  line_vec_t     line_lvl,
    input  line_vec_t     inj_set,
    input  logic          ack_en,
    input  logic [LW-1:0] ack_line,
    output winner_t       win
);

    localparam line_vec_t EDGE_LINES = ~LEVEL_MASK & ~IGNORE_MASK;
    localparam line_vec_t LVL_LINES  = LEVEL_MASK & ~IGNORE_MASK;

    line_vec_t latched;
    line_vec_t prev_lvl;
    line_vec_t rise_hit;
    line_vec_t ack_bits;
    line_vec_t pending;

    always_comb begin
        rise_hit = line_lvl & ~prev_lvl & EDGE_LINES;
        ack_bits = ack_en ? (line_vec_t'(1) << ack_line) : '0;
        pending  = (latched & ~LEVEL_MASK) | (line_lvl & LVL_LINES);
        win      = pick_winner(pending);
    end

    // A new edge or injection in the acknowledge cycle wins over the clear.
    always_ff @(posedge clk) begin
        if (rst) begin
            latched  <= '0;
            prev_lvl <= '0;
        end else begin
            prev_lvl <= line_lvl;
            latched  <= ((latched & ~ack_bits) | rise_hit | inj_set) & ~LEVEL_MASK;
        end
    end

endmodule

// File: rtl/pic_ack_seq.sv
module pic_ack_seq
    import pic_cascade_pkg::*;
#(
    parameter logic [VEC_W-1:0] PRI_BASE = 8'h40,
    parameter logic [VEC_W-1:0] SEC_BASE = 8'h70
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ack_req,
    input  winner_t          pri_win,
    input  winner_t          sec_win,
    output logic             pri_ack_en,
    output logic [LW-1:0]    pri_ack_line,
    output logic             sec_ack_en,
    output logic [LW-1:0]    sec_ack_line,
    output logic             busy,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_valid
);

    seq_state_t       state;
    winner_t          pri_sel;
    logic             cascade_step;
    logic [VEC_W-1:0] vec_next;

    always_comb begin
        busy         = (state != SEQ_IDLE);
        pri_ack_en   = (state == SEQ_PRIMARY) && pri_win.valid;
        pri_ack_line = pri_win.line;
        cascade_step = (state == SEQ_EMIT) && pri_sel.valid && (pri_sel.line == CASCADE_LINE);
        sec_ack_en   = cascade_step && sec_win.valid;
        sec_ack_line = sec_win.line;

        if (!pri_sel.valid)
            vec_next = form_vector(PRI_BASE, SPURIOUS_LINE);
        else if (pri_sel.line != CASCADE_LINE)
            vec_next = form_vector(PRI_BASE, pri_sel.line);
        else if (sec_win.valid)
            vec_next = form_vector(SEC_BASE, sec_win.line);
        else
            vec_next = form_vector(SEC_BASE, SPURIOUS_LINE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SEQ_IDLE;
            pri_sel   <= '0;
            vec_out   <= '0;
            vec_valid <= 1'b0;
        end else begin
            vec_valid <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (ack_req)
                        state <= SEQ_PRIMARY;
                end
                SEQ_PRIMARY: begin
                    pri_sel <= pri_win;
                    state   <= SEQ_EMIT;
                end
                SEQ_EMIT: begin
                    vec_out   <= vec_next;
                    vec_valid <= 1'b1;
                    state     <= SEQ_IDLE;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pic_cascade_top.sv
module pic_cascade_top
    import pic_cascade_pkg::*;
#(
    parameter logic [VEC_W-1:0] MASTER_BASE        = 8'h40,
    parameter logic [VEC_W-1:0] SLAVE_BASE         = 8'h70,
    parameter line_vec_t        MASTER_LEVEL_LINES = 8'h20,
    parameter line_vec_t        SLAVE_LEVEL_LINES  = 8'h40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TOTAL-1:0] req_in,
    input  logic             ack_req,
    output logic             irq_out,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_valid
);

    localparam line_vec_t CASCADE_BIT = line_vec_t'(1) << CASCADE_LINE;

    line_vec_t     ctl_lines [CTRLS];
    winner_t       m_win;
    winner_t       s_win;
    line_vec_t     m_inj;
    logic          busy;
    logic          m_ack_en;
    logic [LW-1:0] m_ack_line;
    logic          s_ack_en;
    logic [LW-1:0] s_ack_line;

    for (genvar g = 0; g < CTRLS; g++) begin : g_route
        assign ctl_lines[g] = req_in[g*LINES +: LINES];
    end

    // Cascade request reaches primary line 2 only between sequences.
    assign m_inj   = (s_win.valid && !busy) ? CASCADE_BIT : '0;
    assign irq_out = m_win.valid;

    pic_line_resolver #(
        .LEVEL_MASK (MASTER_LEVEL_LINES & ~CASCADE_BIT),
        .IGNORE_MASK(CASCADE_BIT)
    ) u_master (
        .clk     (clk),
        .rst     (rst),
        .line_lvl(ctl_lines[0]),
        .inj_set (m_inj),
        .ack_en  (m_ack_en),
        .ack_line(m_ack_line),
        .win     (m_win)
    );

    pic_line_resolver #(
        .LEVEL_MASK (SLAVE_LEVEL_LINES),
        .IGNORE_MASK('0)
    ) u_slave (
        .clk     (clk),
        .rst     (rst),
        .line_lvl(ctl_lines[1]),
        .inj_set ('0),
        .ack_en  (s_ack_en),
        .ack_line(s_ack_line),
        .win     (s_win)
    );

    pic_ack_seq #(
        .PRI_BASE(MASTER_BASE),
        .SEC_BASE(SLAVE_BASE)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .ack_req     (ack_req),
        .pri_win     (m_win),
        .sec_win     (s_win),
        .pri_ack_en  (m_ack_en),
        .pri_ack_line(m_ack_line),
        .sec_ack_en  (s_ack_en),
        .sec_ack_line(s_ack_line),
        .busy        (busy),
        .vec_out     (vec_out),
        .vec_valid   (vec_valid)
    );

endmodule

// File: rtl/pic_cascade_chk.sv
module pic_cascade_chk #(
    parameter logic [7:0] MASTER_BASE = 8'h40
) (
    input logic       clk,
    input logic       rst,
    input logic       ack_req,
    input logic       irq_out,
    input logic [7:0] vec_out,
    input logic       vec_valid,
    input logic       s_win_valid,
    input logic       busy,
    input logic       m_ack_en,
    input logic       s_ack_en
);

    // R5
    vec_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        vec_valid |=> !vec_valid);

    // R5
    ack_latency_chk: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> $past(ack_req, 3));

    // R3
    cascade_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (s_win_valid && !busy) |=> irq_out);

    // R6
    single_ack_chk: assert property (@(posedge clk) disable iff (rst)
        !(m_ack_en && s_ack_en));

    // R7
    no_cascade_vector_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && vec_out[7:3] == MASTER_BASE[7:3]) |-> (vec_out[2:0] != 3'd2));

endmodule

bind pic_cascade_top pic_cascade_chk #(.MASTER_BASE(MASTER_BASE)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ack_req    (ack_req),
    .irq_out    (irq_out),
    .vec_out    (vec_out),
    .vec_valid  (vec_valid),
    .s_win_valid(s_win.valid),
    .busy       (busy),
    .m_ack_en   (m_ack_en),
    .s_ack_en   (s_ack_en)
);

// File: tb/tb_pic_cascade_top.sv
`timescale 1ns/1ps
module tb_pic_cascade_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] req_in = '0;
    logic        ack_req = 1'b0;
    logic        irq_out;
    logic [7:0]  vec_out;
    logic        vec_valid;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    pic_cascade_top dut (
        .clk      (clk),
        .rst      (rst),
        .req_in   (req_in),
        .ack_req  (ack_req),
        .irq_out  (irq_out),
        .vec_out  (vec_out),
        .vec_valid(vec_valid)
    );

    // pattern, vector of first acknowledge, vector of second acknowledge
    localparam int NTAB = 9;
    localparam logic [31:0] TAB [NTAB] = '{
        {16'h0001, 8'h40, 8'h47},   // R1 primary line 0, then R8 spurious
        {16'h0040, 8'h46, 8'h47},   // R1 primary line 6
        {16'h0100, 8'h70, 8'h47},   // R1 secondary line 0
        {16'h2000, 8'h75, 8'h47},   // R1 secondary line 5
        {16'h0018, 8'h43, 8'h44},   // R4 primary 3 over 4
        {16'h0202, 8'h41, 8'h71},   // R4 line 1 over cascade
        {16'h0208, 8'h71, 8'h43},   // R4 cascade over line 3
        {16'h1200, 8'h71, 8'h74},   // R7 secondary re-raise
        {16'h0004, 8'h47, 8'h47}    // R3 input 2 ignored
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_ack(output logic [7:0] v);
        logic early;
        @(negedge clk) ack_req = 1'b1;
        @(negedge clk) ack_req = 1'b0;
        @(negedge clk) early = vec_valid;
        @(negedge clk);
        chk(!early && vec_valid, "R5", {early, vec_valid}, 2'b01);
        v = vec_out;
        @(negedge clk);
        chk(!vec_valid, "R5", vec_valid, 0);
    endtask

    initial begin
        logic [7:0] v;
        int pulses;
        repeat (4) @(negedge clk);
        chk(!irq_out && !vec_valid && vec_out == 8'h00, "R11", {irq_out, vec_valid, vec_out}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!irq_out && !vec_valid && vec_out == 8'h00, "R11", {irq_out, vec_valid, vec_out}, 0);

        for (int k = 0; k < NTAB; k++) begin
            logic [15:0] pat;
            pat = TAB[k][31:16];
            @(negedge clk) req_in = pat;
            @(negedge clk) req_in = '0;
            repeat (2) @(negedge clk);
            chk(irq_out == ((pat & ~16'h0004) != 0), "R2/R3", irq_out, ((pat & ~16'h0004) != 0));
            do_ack(v);
            chk(v == TAB[k][15:8], "R1/R4/R6", v, TAB[k][15:8]);
            repeat (2) @(negedge clk);
            do_ack(v);
            chk(v == TAB[k][7:0], "R4/R7/R8", v, TAB[k][7:0]);
            repeat (2) @(negedge clk);
            chk(!irq_out, "R6/R7", irq_out, 0);
        end

        // R5: ack_req held across a whole sequence gives a single vector
        @(negedge clk) req_in = 16'h0003;
        @(negedge clk) req_in = '0;
        repeat (2) @(negedge clk);
        @(negedge clk) ack_req = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(!vec_valid, "R5", vec_valid, 0);
        @(negedge clk);
        chk(vec_valid && vec_out == 8'h40, "R5", {vec_valid, vec_out}, 9'h140);
        ack_req = 1'b0;
        pulses = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (vec_valid) pulses++;
        end
        chk(pulses == 0, "R5", pulses, 0);
        chk(irq_out, "R5", irq_out, 1);
        do_ack(v);
        chk(v == 8'h41, "R5", v, 8'h41);
        repeat (2) @(negedge clk);

        // R10 / R9: level-following secondary line 6 (input 14)
        @(negedge clk) req_in = 16'h4000;
        repeat (2) @(negedge clk);
        chk(irq_out, "R10", irq_out, 1);
        do_ack(v);
        chk(v == 8'h76, "R10", v, 8'h76);
        repeat (2) @(negedge clk);
        chk(irq_out, "R10", irq_out, 1);
        do_ack(v);
        chk(v == 8'h76, "R10", v, 8'h76);
        @(negedge clk) req_in = '0;
        repeat (2) @(negedge clk);
        chk(irq_out, "R9", irq_out, 1);
        do_ack(v);
        chk(v == 8'h77, "R9", v, 8'h77);
        repeat (2) @(negedge clk);
        chk(!irq_out, "R9", irq_out, 0);

        // R10: level-following primary line 5 tracks its input
        @(negedge clk) req_in = 16'h0020;
        @(negedge clk);
        chk(irq_out, "R10", irq_out, 1);
        req_in = '0;
        @(negedge clk);
        chk(!irq_out, "R10", irq_out, 0);
        do_ack(v);
        chk(v == 8'h47, "R10", v, 8'h47);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule